// File: doc/BRIEF.md
# Triple-Commit Write-Protect Lock Controller

This block owns the 8-bit control register of a timekeeping memory device and decides which of its three counters (real-time clock, interval timer, cycle counter) and their alarm registers may still be written. A decoded copy strobe arrives with its target address, the result of the authorization comparison, the authorization-accepted bit carried in the presented pattern, and the staged control byte. Ordinary control bits are written on a single accepted copy. The three protection bits are only written on the third back-to-back accepted copy that carries identical protection bits.

Once any protection bit is set, the register is locked for good. The protection bits freeze. The oscillator-enable bit can only be raised. The stop/start bit is held at zero. The read-only, delay-select and auto/manual bits freeze. The write-enable masks drop for every protected counter and its alarm. When the alarm of a protected counter fires, the block enters a sticky expired state. In that state the permit output for the presented command class is restricted according to the read-only bit. Only the active-low reset clears the register, the sequence counter and the expired state.

Top module: `wpl_lock_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00, both write-enable masks are all ones, the accepted flag and the expired flag are 0, and every command class is permitted.
- R2: Control byte layout: bit0 oscillator enable, bit1 stop/start, bit2 auto/manual, bit3 delay select, bit4 read-only, bit5/bit6/bit7 protect real-time clock / interval timer / cycle counter. While unlocked, an accepted copy to the control address loads bits 4..0 one edge later. The first and second copies never set bits 7..5.
- R3: Bits 7..5 load on the third consecutive accepted copy with identical staged bits 7..5. On the second and third copies, the presented accepted bit must be 1; otherwise the copy is rejected, writes nothing and restarts the sequence. On the loading copy, bit1 is written as 0 if any loaded protection bit is 1.
- R4: The sequence restarts on a copy that fails authorization or targets an address other than the control address. These copies write nothing. A copy whose staged protection bits differ from the previous copy counts as the first copy of a new sequence.
- R5: The accepted flag becomes 1 on the edge after the first copy that passes authorization and stays 1 until reset.
- R6: Counter and alarm write-enable bit i is 0 exactly when protection bit 5+i is set. An enable never returns to 1 without reset.
- R7: Once any protection bit is 1, bits 7..5 never change again.
- R8: Once locked, bit0 can be raised by a copy but never cleared.
- R9: Once locked, bit1 stays 0 and bits 4..2 never change.
- R10: The expired flag rises one edge after the alarm of a protected counter is high and then stays high. The alarm of an unprotected counter has no effect.
- R11: Command class encoding: 0 ROM, 1 read scratchpad, 2 read memory, 3 other memory. The permit output is combinational. It is 1 for every class while not expired. Once expired, class 0 is always permitted, classes 1 and 2 are permitted only when bit4 is 1, and class 3 is never permitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| copy_stb_i | input | 1 | One-cycle copy command strobe |
| copy_addr_i | input | ADDR_W | Target address of the copy |
| copy_auth_ok_i | input | 1 | Authorization pattern matched |
| copy_aa_i | input | 1 | Accepted bit as presented in the pattern |
| copy_ctrl_i | input | 8 | Staged control byte |
| alarm_i | input | 3 | Alarm flags: bit0 clock, bit1 interval, bit2 cycle |
| cmd_class_i | input | 2 | Decoded command class |
| cnt_wr_en_o | output | 3 | Counter write enables |
| alm_wr_en_o | output | 3 | Alarm register write enables |
| ctrl_o | output | 8 | Current control register |
| auth_acc_o | output | 1 | Authorization-accepted flag |
| expired_o | output | 1 | Sticky expiration state |
| cmd_permit_o | output | 1 | Presented command class is permitted |

## Verification
The control register, the masks, the accepted flag and the expired flag are all registered. Each one changes on the first rising edge that sees the copy strobe or the alarm. The permit output follows the command class in the same cycle, based on the state already held. The bench therefore changes inputs on a falling edge and compares every result on the next falling edge. At that point exactly one rising edge has gone by, and the class under test is still applied.

// File: rtl/wpl_pkg.sv
// Shared types for the write-protect lock controller.
// Assumes an 8-bit control register with the protection bits in the top three positions.
package wpl_pkg;

    localparam int NUM_CNT = 3;

    typedef enum logic [1:0] {
        CMD_ROM    = 2'd0,
        CMD_RD_PAD = 2'd1,
        CMD_RD_MEM = 2'd2,
        CMD_OTHER  = 2'd3
    } cmd_class_e;

    typedef struct packed {
        logic [NUM_CNT-1:0] lock;   // bit7 cycle, bit6 interval, bit5 clock
        logic               ro;     // bit4
        logic               dsel;   // bit3
        logic               autom;  // bit2
        logic               run;    // bit1
        logic               osc;    // bit0
    } ctrl_t;

endpackage

// File: rtl/wpl_commit_seq.sv
// Counts consecutive accepted copies to the control address and flags the
// copy that may load the protection bits. It also holds the accepted flag.
// Assumes COMMITS_REQ >= 2 and a one-cycle copy strobe.
module wpl_commit_seq
    import wpl_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int CTRL_ADDR   = 25,
    parameter int COMMITS_REQ = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stb_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               auth_ok_i,
    input  logic               aa_i,
    input  logic [NUM_CNT-1:0] lock_stage_i,
    input  logic               locked_i,
    output logic               ctrl_wr_o,
    output logic               lock_apply_o,
    output logic               aa_flag_o
);

    localparam int SEQ_W = $clog2(COMMITS_REQ + 1);
    localparam logic [SEQ_W-1:0]  LAST_STEP = SEQ_W'(COMMITS_REQ - 1);
    localparam logic [ADDR_W-1:0] CTRL_A    = ADDR_W'(CTRL_ADDR);

    logic [SEQ_W-1:0]   seq_q;
    logic [NUM_CNT-1:0] prev_q;
    logic               aa_q;
    logic               hit, seq_idle, aa_ok, same;

    // Decode whether this strobe is an acceptable copy to the control register.
    always_comb begin
        hit          = stb_i && auth_ok_i && (addr_i == CTRL_A);
        seq_idle     = (seq_q == '0);
        aa_ok        = seq_idle || aa_i;
        same         = (lock_stage_i == prev_q);
        ctrl_wr_o    = hit && aa_ok;
        lock_apply_o = ctrl_wr_o && !locked_i && !seq_idle && same
                       && (seq_q == LAST_STEP);
    end

    // Advance, restart or clear the commit sequence on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q  <= '0;
            prev_q <= '0;
        end else if (stb_i) begin
            if (!hit || locked_i || !aa_ok) begin
                seq_q <= '0;
            end else if (seq_idle || !same) begin
                seq_q  <= SEQ_W'(1);
                prev_q <= lock_stage_i;
            end else if (lock_apply_o) begin
                seq_q <= '0;
            end else begin
                seq_q <= seq_q + SEQ_W'(1);
            end
        end
    end

    // Raise the accepted flag on the first copy that passes authorization.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aa_q <= 1'b0;
        end else if (stb_i && auth_ok_i) begin
            aa_q <= 1'b1;
        end
    end

    assign aa_flag_o = aa_q;

endmodule

// File: rtl/wpl_ctrl_reg.sv
// Holds the control register and applies the lock rules: it freezes the
// protected fields, lets the oscillator bit only rise and holds stop/start at zero.
// Assumes ctrl_wr_i and lock_apply_i come from wpl_commit_seq in the same cycle.
module wpl_ctrl_reg
    import wpl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ctrl_wr_i,
    input  logic  lock_apply_i,
    input  ctrl_t staged_i,
    output ctrl_t ctrl_o,
    output logic  locked_o
);

    ctrl_t q, d;

    // Next-state rules for the control register.
    always_comb begin
        d = q;
        if (ctrl_wr_i) begin
            if (locked_o) begin
                d.osc = q.osc | staged_i.osc;
                d.run = 1'b0;
            end else begin
                d.osc   = staged_i.osc;
                d.run   = staged_i.run;
                d.autom = staged_i.autom;
                d.dsel  = staged_i.dsel;
                d.ro    = staged_i.ro;
                if (lock_apply_i) begin
                    d.lock = staged_i.lock;
                    d.run  = staged_i.run & ~(|staged_i.lock);
                end
            end
        end
    end

    // Register the control byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ctrl_o   = q;
    assign locked_o = |q.lock;

endmodule

// File: rtl/wpl_expiry.sv
// Tracks the sticky expired state and gates the command class.
// Assumes lock_i and ro_i come from the registered control byte.
module wpl_expiry
    import wpl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] lock_i,
    input  logic [NUM_CNT-1:0] alarm_i,
    input  logic               ro_i,
    input  logic [1:0]         cmd_class_i,
    output logic               expired_o,
    output logic               permit_o
);

    logic expired_q;

    // Latch expiration when any protected counter raises its alarm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expired_q <= 1'b0;
        end else if (|(lock_i & alarm_i)) begin
            expired_q <= 1'b1;
        end
    end

    // Decide whether the presented command class may run.
    always_comb begin
        if (!expired_q) begin
            permit_o = 1'b1;
        end else begin
            case (cmd_class_e'(cmd_class_i))
                CMD_ROM:              permit_o = 1'b1;
                CMD_RD_PAD, CMD_RD_MEM: permit_o = ro_i;
                default:              permit_o = 1'b0;
            endcase
        end
    end

    assign expired_o = expired_q;

endmodule

// File: rtl/wpl_lock_ctrl.sv
// Top of the write-protect lock controller. It ties together the commit sequencer,
// the control register and the expiry logic, and derives a write-enable
// mask for each counter and its alarm.
// Assumes copy strobes are decoded one-cycle pulses.
module wpl_lock_ctrl
    import wpl_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int CTRL_ADDR   = 25,
    parameter int COMMITS_REQ = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               copy_stb_i,
    input  logic [ADDR_W-1:0]  copy_addr_i,
    input  logic               copy_auth_ok_i,
    input  logic               copy_aa_i,
    input  logic [7:0]         copy_ctrl_i,
    input  logic [NUM_CNT-1:0] alarm_i,
    input  logic [1:0]         cmd_class_i,
    output logic [NUM_CNT-1:0] cnt_wr_en_o,
    output logic [NUM_CNT-1:0] alm_wr_en_o,
    output logic [7:0]         ctrl_o,
    output logic               auth_acc_o,
    output logic               expired_o,
    output logic               cmd_permit_o
);

    ctrl_t staged, ctrl_q;
    logic  ctrl_wr, lock_apply, locked;

    assign staged = ctrl_t'(copy_ctrl_i);

    wpl_commit_seq #(
        .ADDR_W      (ADDR_W),
        .CTRL_ADDR   (CTRL_ADDR),
        .COMMITS_REQ (COMMITS_REQ)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .stb_i        (copy_stb_i),
        .addr_i       (copy_addr_i),
        .auth_ok_i    (copy_auth_ok_i),
        .aa_i         (copy_aa_i),
        .lock_stage_i (staged.lock),
        .locked_i     (locked),
        .ctrl_wr_o    (ctrl_wr),
        .lock_apply_o (lock_apply),
        .aa_flag_o    (auth_acc_o)
    );

    wpl_ctrl_reg u_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr_i    (ctrl_wr),
        .lock_apply_i (lock_apply),
        .staged_i     (staged),
        .ctrl_o       (ctrl_q),
        .locked_o     (locked)
    );

    wpl_expiry u_exp (
        .clk         (clk),
        .rst_n       (rst_n),
        .lock_i      (ctrl_q.lock),
        .alarm_i     (alarm_i),
        .ro_i        (ctrl_q.ro),
        .cmd_class_i (cmd_class_i),
        .expired_o   (expired_o),
        .permit_o    (cmd_permit_o)
    );

    // One write-enable pair per counter, each dropped by its own protection bit.
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_mask
        assign cnt_wr_en_o[i] = ~ctrl_q.lock[i];
        assign alm_wr_en_o[i] = ~ctrl_q.lock[i];
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/wpl_lock_ctrl_chk.sv
// Temporal checks on the lock controller's ports, bound to the top module.
module wpl_lock_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ctrl_i,
    input logic [2:0] cnt_wr_en_i,
    input logic [2:0] alm_wr_en_i,
    input logic       expired_i,
    input logic       permit_i,
    input logic [1:0] cmd_class_i
);

    assert_lock_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|ctrl_i[7:5]) |=> (ctrl_i[7:5] == $past(ctrl_i[7:5])));

    assert_osc_one_way_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ctrl_i[7:5]) && ctrl_i[0]) |=> ctrl_i[0]);

    assert_run_held_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|ctrl_i[7:5]) |-> !ctrl_i[1]);

    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|ctrl_i[7:5]) |=> (ctrl_i[4:2] == $past(ctrl_i[4:2])));

    assert_mask_no_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cnt_wr_en_i & ~$past(cnt_wr_en_i)) == 3'b000));

    assert_mask_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_en_i == alm_wr_en_i);

    assert_expired_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        expired_i |=> expired_i);

    assert_rom_permit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_class_i == 2'd0) |-> permit_i);

    assert_live_permit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !expired_i |-> permit_i);

endmodule

bind wpl_lock_ctrl wpl_lock_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_i      (ctrl_o),
    .cnt_wr_en_i (cnt_wr_en_o),
    .alm_wr_en_i (alm_wr_en_o),
    .expired_i   (expired_o),
    .permit_i    (cmd_permit_o),
    .cmd_class_i (cmd_class_i)
);

// File: tb/wpl_lock_ctrl_tb.sv
module wpl_lock_ctrl_tb;

    localparam int ADDR_W = 6;
    localparam logic [5:0] CA = 6'd25;

    typedef struct packed {
        logic       stb;
        logic [5:0] addr;
        logic       auth;
        logic       aa;
        logic [7:0] data;
        logic [2:0] alarm;
        logic [1:0] cls;
        logic [7:0] exp_ctrl;
        logic [2:0] exp_mask;
        logic       exp_permit;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 6'd0, 1'b0, 1'b0, 8'h00, 3'b000, 2'd3, 8'h00, 3'b111, 1'b1, 4'd1},  // R1 idle
        '{1'b1, CA,   1'b1, 1'b0, 8'h33, 3'b000, 2'd3, 8'h13, 3'b111, 1'b1, 4'd2},  // R2 first
        '{1'b1, CA,   1'b1, 1'b1, 8'h33, 3'b000, 2'd3, 8'h13, 3'b111, 1'b1, 4'd2},  // R2 second
        '{1'b1, CA,   1'b0, 1'b1, 8'h33, 3'b000, 2'd3, 8'h13, 3'b111, 1'b1, 4'd4},  // R4 auth fail
        '{1'b1, CA,   1'b1, 1'b1, 8'h33, 3'b000, 2'd3, 8'h13, 3'b111, 1'b1, 4'd4},  // R4 seq 1
        '{1'b1, 6'd5, 1'b1, 1'b1, 8'h33, 3'b000, 2'd3, 8'h13, 3'b111, 1'b1, 4'd4},  // R4 other addr
        '{1'b1, CA,   1'b1, 1'b0, 8'h33, 3'b000, 2'd3, 8'h13, 3'b111, 1'b1, 4'd4},  // R4 seq 1
        '{1'b1, CA,   1'b1, 1'b1, 8'h53, 3'b000, 2'd3, 8'h13, 3'b111, 1'b1, 4'd4},  // R4 differ
        '{1'b1, CA,   1'b1, 1'b1, 8'h33, 3'b000, 2'd3, 8'h13, 3'b111, 1'b1, 4'd4},  // R4 differ
        '{1'b1, CA,   1'b1, 1'b0, 8'h30, 3'b000, 2'd3, 8'h13, 3'b111, 1'b1, 4'd3},  // R3 aa missing
        '{1'b1, CA,   1'b1, 1'b0, 8'h33, 3'b000, 2'd3, 8'h13, 3'b111, 1'b1, 4'd3},  // R3 seq 1
        '{1'b1, CA,   1'b1, 1'b1, 8'h33, 3'b000, 2'd3, 8'h13, 3'b111, 1'b1, 4'd3},  // R3 seq 2
        '{1'b1, CA,   1'b1, 1'b1, 8'h33, 3'b000, 2'd3, 8'h31, 3'b110, 1'b1, 4'd3},  // R3 lock
        '{1'b1, CA,   1'b1, 1'b1, 8'hEC, 3'b000, 2'd3, 8'h31, 3'b110, 1'b1, 4'd7},  // R7 R9 frozen
        '{1'b0, 6'd0, 1'b0, 1'b0, 8'h00, 3'b010, 2'd3, 8'h31, 3'b110, 1'b1, 4'd10}, // R10 free alarm
        '{1'b0, 6'd0, 1'b0, 1'b0, 8'h00, 3'b001, 2'd3, 8'h31, 3'b110, 1'b0, 4'd11}, // R11 expire
        '{1'b0, 6'd0, 1'b0, 1'b0, 8'h00, 3'b000, 2'd1, 8'h31, 3'b110, 1'b1, 4'd11}, // R11 rd pad
        '{1'b0, 6'd0, 1'b0, 1'b0, 8'h00, 3'b000, 2'd2, 8'h31, 3'b110, 1'b1, 4'd11}, // R11 rd mem
        '{1'b0, 6'd0, 1'b0, 1'b0, 8'h00, 3'b000, 2'd0, 8'h31, 3'b110, 1'b1, 4'd11}, // R11 rom
        '{1'b0, 6'd0, 1'b0, 1'b0, 8'h00, 3'b000, 2'd3, 8'h31, 3'b110, 1'b0, 4'd10}  // R10 sticky
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              copy_stb_i = 1'b0;
    logic [ADDR_W-1:0] copy_addr_i = '0;
    logic              copy_auth_ok_i = 1'b0;
    logic              copy_aa_i = 1'b0;
    logic [7:0]        copy_ctrl_i = '0;
    logic [2:0]        alarm_i = '0;
    logic [1:0]        cmd_class_i = '0;
    logic [2:0]        cnt_wr_en_o, alm_wr_en_o;
    logic [7:0]        ctrl_o;
    logic              auth_acc_o, expired_o, cmd_permit_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    wpl_lock_ctrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(25), .COMMITS_REQ(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .copy_stb_i(copy_stb_i), .copy_addr_i(copy_addr_i),
        .copy_auth_ok_i(copy_auth_ok_i), .copy_aa_i(copy_aa_i), .copy_ctrl_i(copy_ctrl_i),
        .alarm_i(alarm_i), .cmd_class_i(cmd_class_i), .cnt_wr_en_o(cnt_wr_en_o),
        .alm_wr_en_o(alm_wr_en_o), .ctrl_o(ctrl_o), .auth_acc_o(auth_acc_o),
        .expired_o(expired_o), .cmd_permit_o(cmd_permit_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic stb, input logic [5:0] addr, input logic auth,
                         input logic aa, input logic [7:0] data, input logic [2:0] alarm,
                         input logic [1:0] cls);
        copy_stb_i = stb; copy_addr_i = addr; copy_auth_ok_i = auth;
        copy_aa_i = aa; copy_ctrl_i = data; alarm_i = alarm; cmd_class_i = cls;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        apply(1'b0, 6'd0, 1'b0, 1'b0, 8'h00, 3'b000, 2'd3);
        apply(1'b0, 6'd0, 1'b0, 1'b0, 8'h00, 3'b000, 2'd3);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1", "ctrl", ctrl_o, 8'h00);
        check("R1", "mask", cnt_wr_en_o, 3'b111);
        check("R1", "aa", auth_acc_o, 0);
        check("R1", "expired", expired_o, 0);

        // Table walk: inputs at a falling edge, outputs at the next falling edge.
        for (int i = 0; i < NV; i++) begin
            string tag;
            apply(VEC[i].stb, VEC[i].addr, VEC[i].auth, VEC[i].aa, VEC[i].data,
                  VEC[i].alarm, VEC[i].cls);
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            check(tag, "ctrl", ctrl_o, VEC[i].exp_ctrl);
            check(tag, "cnt mask", cnt_wr_en_o, VEC[i].exp_mask);
            check(tag, "alm mask", alm_wr_en_o, VEC[i].exp_mask);
            check(tag, "permit", cmd_permit_o, VEC[i].exp_permit);
        end

        // Second scenario: clear read-only bit, oscillator raised after lock.
        do_reset();
        check("R1", "ctrl after reset", ctrl_o, 8'h00);
        check("R1", "expired after reset", expired_o, 0);
        check("R5", "aa before copy", auth_acc_o, 0);
        apply(1'b1, CA, 1'b1, 1'b0, 8'hC2, 3'b000, 2'd3);
        check("R5", "aa after first copy", auth_acc_o, 1);
        check("R2", "ctrl first copy", ctrl_o, 8'h02);
        apply(1'b1, CA, 1'b1, 1'b1, 8'hC2, 3'b000, 2'd3);
        check("R2", "ctrl second copy", ctrl_o, 8'h02);
        apply(1'b1, CA, 1'b1, 1'b1, 8'hC2, 3'b000, 2'd3);
        check("R3", "ctrl locked, run forced", ctrl_o, 8'hC0);
        check("R6", "cnt mask two locked", cnt_wr_en_o, 3'b001);
        apply(1'b1, CA, 1'b1, 1'b1, 8'h01, 3'b000, 2'd3);
        check("R8", "osc raised", ctrl_o, 8'hC1);
        apply(1'b1, CA, 1'b1, 1'b1, 8'h00, 3'b000, 2'd3);
        check("R8", "osc not cleared", ctrl_o, 8'hC1);
        apply(1'b1, CA, 1'b1, 1'b1, 8'h1E, 3'b000, 2'd3);
        check("R9", "ro dsel auto run frozen", ctrl_o, 8'hC1);
        apply(1'b0, 6'd0, 1'b0, 1'b0, 8'h00, 3'b001, 2'd3);
        check("R10", "clock alarm unprotected", expired_o, 0);
        apply(1'b0, 6'd0, 1'b0, 1'b0, 8'h00, 3'b100, 2'd1);
        check("R10", "cycle alarm expires", expired_o, 1);
        check("R11", "rd pad denied ro=0", cmd_permit_o, 0);
        apply(1'b0, 6'd0, 1'b0, 1'b0, 8'h00, 3'b000, 2'd2);
        check("R11", "rd mem denied ro=0", cmd_permit_o, 0);
        apply(1'b0, 6'd0, 1'b0, 1'b0, 8'h00, 3'b000, 2'd0);
        check("R11", "rom allowed", cmd_permit_o, 1);
        check("R6", "alm mask two locked", alm_wr_en_o, 3'b001);

        finish_run();
    end

endmodule